// File: doc/BRIEF.md
# Signed-Count Barrel Shifter

This block shifts a 32-bit data word by a distance and direction taken from a 32-bit signed count word. A non-negative count shifts the data left. A negative count shifts it right. In both cases only the count's sign bit and its five lowest bits are used. A mode input selects the fill for right shifts: arithmetic mode copies the data's sign bit, and logical mode fills with zeros. A left shift always fills with zeros.

A negative count whose five low bits are all zero stands for a right shift across the whole word. In that case the result is made entirely of fill bits. The block produces no flags.

An optional register stage sits on the operand inputs. With it, the result appears one clock after the operands are presented. Without it, the block is purely combinational.

Top module: `sc_shifter`

## Requirements
- R1: When count bit 31 is 0, the output equals the data shifted left by count[4:0] positions, with zeros entering at bit 0.
- R2: When count bit 31 is 1 and count[4:0] is nonzero, the data shifts right by 32 minus count[4:0]. That equals the bitwise inverse of count[4:0] plus one, so a count of -1 shifts right by one.
- R3: For a right shift, arithMode = 1 fills the vacated upper bits with data bit 31, and arithMode = 0 fills them with zeros.
- R4: When count bit 31 is 1, count[4:0] is 0 and arithMode = 1, the output is all ones if data bit 31 is 1 and all zeros otherwise.
- R5: When count bit 31 is 1, count[4:0] is 0 and arithMode = 0, the output is zero whatever the data.
- R6: Count bits 30 to 5 have no effect on the output.
- R7: With PIPE_EN = 1, the output reflects the operands sampled at the previous rising clock edge. With PIPE_EN = 0, it follows the current operands.
- R8: With PIPE_EN = 1, the output reads zero while rstN is low and until the first operands are captured after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional operand register |
| rstN | input | 1 | Active-low asynchronous reset |
| dataIn | input | 32 | Word to be shifted |
| countIn | input | 32 | Signed shift count; sign gives direction |
| arithMode | input | 1 | 1 = arithmetic (sign fill) right shift, 0 = logical |
| dataOut | output | 32 | Shifted result |

## Verification
On every clock, the assertions check the properties that hold whatever the data is. After a left shift, the low bits the shift vacated must be zero. After a logical right shift, the high bits it vacated must be zero. After an arithmetic right shift, the result must keep the data's sign bit. The two full-width cases must produce their fixed patterns. The exact output value for each data word and distance, the fact that count bits 30 to 5 are ignored, the one-cycle latency and the reset value can only be shown by the bench. It walks every combination of sign and low count bits in both modes against its own reference model, and it adds directed cases for junk count bits and for reset.

// File: rtl/sc_shifter_pkg.sv
package sc_shifter_pkg;

  // Strobes passed from the count decoder to the shifting datapath.
  typedef struct packed {
    logic goRight;   // shift toward bit 0
    logic fullSpan;  // right shift across the whole word
    logic signFill;  // right-shift fill comes from the data sign bit
  } shiftCtrl_t;

endpackage

// File: rtl/sc_shift_ctrl.sv
module sc_shift_ctrl
  import sc_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] countIn,
  input  logic              arithMode,
  output shiftCtrl_t        ctrl,
  output logic [AMT_W-1:0]  amount
);

  logic             negCount;
  logic [AMT_W-1:0] lowBits;

  assign negCount = countIn[DATA_W-1];
  assign lowBits  = countIn[AMT_W-1:0];

  always_comb begin
    ctrl.goRight  = negCount;
    ctrl.fullSpan = negCount && (lowBits == '0);
    ctrl.signFill = arithMode;
    // Right distance is the two's complement of the low field.
    amount = negCount ? (~lowBits + AMT_W'(1)) : lowBits;
  end

endmodule

// File: rtl/sc_shift_datapath.sv
module sc_shift_datapath
  import sc_shifter_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] dataIn,
  input  shiftCtrl_t        ctrl,
  input  logic [AMT_W-1:0]  amount,
  output logic [DATA_W-1:0] dataOut
);

  logic              fillBit;
  logic [DATA_W-1:0] stage [0:AMT_W];

  assign fillBit  = ctrl.goRight && ctrl.signFill && dataIn[DATA_W-1];
  assign stage[0] = dataIn;

  // One log-step per amount bit; each stage moves by a power of two.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    logic [DATA_W-1:0] movedLeft;
    logic [DATA_W-1:0] movedRight;
    assign movedLeft  = {stage[k][DATA_W-1-STEP:0], {STEP{1'b0}}};
    assign movedRight = {{STEP{fillBit}}, stage[k][DATA_W-1:STEP]};
    assign stage[k+1] = !amount[k] ? stage[k]
                      : (ctrl.goRight ? movedRight : movedLeft);
  end

  assign dataOut = ctrl.fullSpan ? {DATA_W{fillBit}} : stage[AMT_W];

endmodule

// File: rtl/sc_shifter.sv
module sc_shifter
  import sc_shifter_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter bit PIPE_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] countIn,
  input  logic              arithMode,
  output logic [DATA_W-1:0] dataOut
);

  localparam int AMT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] opData;
  logic [DATA_W-1:0] opCount;
  logic              opArith;
  shiftCtrl_t        ctrl;
  logic [AMT_W-1:0]  amount;

  if (PIPE_EN) begin : g_pipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        opData  <= '0;
        opCount <= '0;
        opArith <= 1'b0;
      end else begin
        opData  <= dataIn;
        opCount <= countIn;
        opArith <= arithMode;
      end
    end
  end else begin : g_comb
    assign opData  = dataIn;
    assign opCount = countIn;
    assign opArith = arithMode;
  end

  sc_shift_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .countIn  (opCount),
    .arithMode(opArith),
    .ctrl     (ctrl),
    .amount   (amount)
  );

  sc_shift_datapath #(.DATA_W(DATA_W)) u_dp (
    .dataIn (opData),
    .ctrl   (ctrl),
    .amount (amount),
    .dataOut(dataOut)
  );

  // Checks relating the result to the operands that produced it.
  logic [AMT_W-1:0] opLow;
  logic             opNeg;
  assign opLow = opCount[AMT_W-1:0];
  assign opNeg = opCount[DATA_W-1];

  a_r1_left_low_zero: assert property (@(posedge clk) disable iff (!rstN)
    !opNeg |-> ((dataOut & ((DATA_W'(1) << opLow) - DATA_W'(1))) == '0));

  a_r3_logical_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (opNeg && !opArith && opLow != '0) |-> ((dataOut >> opLow) == '0));

  a_r3_arith_sign_kept: assert property (@(posedge clk) disable iff (!rstN)
    (opNeg && opArith && opLow != '0) |-> (dataOut[DATA_W-1] == opData[DATA_W-1]));

  a_r4_arith_full: assert property (@(posedge clk) disable iff (!rstN)
    (opNeg && opArith && opLow == '0) |-> (dataOut == {DATA_W{opData[DATA_W-1]}}));

  a_r5_logical_full: assert property (@(posedge clk) disable iff (!rstN)
    (opNeg && !opArith && opLow == '0) |-> (dataOut == '0));

endmodule

// File: tb/sc_shifter_tb.sv
`timescale 1ns/1ps
module sc_shifter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] dataIn = '0;
  logic [31:0] countIn = '0;
  logic        arithMode = 1'b0;
  logic [31:0] dataOut;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sc_shifter #(.DATA_W(32), .PIPE_EN(1'b1)) u_dut (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .countIn(countIn),
    .arithMode(arithMode), .dataOut(dataOut)
  );

  function automatic logic [31:0] refShift(logic [31:0] d, logic [31:0] c, logic a);
    int n;
    if (!c[31]) return d << c[4:0];
    if (c[4:0] == 5'd0) return (a && d[31]) ? 32'hFFFF_FFFF : 32'h0;
    n = 32 - int'(c[4:0]);
    return a ? 32'($signed(d) >>> n) : (d >> n);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Present operands after a falling edge; result is sampled one full cycle later.
  task automatic apply(logic [31:0] d, logic [31:0] c, logic a);
    @(negedge clk);
    dataIn = d; countIn = c; arithMode = a;
    @(negedge clk);
  endtask

  // {data, count, arith, expected}
  localparam logic [96:0] VEC [0:9] = '{
    {32'h0000_00F1, 32'h0000_0004, 1'b0, 32'h0000_0F10},  // R1
    {32'h8000_0001, 32'h0000_0001, 1'b1, 32'h0000_0002},  // R1
    {32'h0000_0001, 32'h0000_001F, 1'b0, 32'h8000_0000},  // R1
    {32'h1234_5678, 32'hFFFF_FFFF, 1'b0, 32'h091A_2B3C},  // R2
    {32'hF000_0000, 32'hFFFF_FFFC, 1'b1, 32'hFF00_0000},  // R3
    {32'hF000_0000, 32'hFFFF_FFFC, 1'b0, 32'h0F00_0000},  // R3
    {32'h8000_0000, 32'h8000_0000, 1'b1, 32'hFFFF_FFFF},  // R4
    {32'h7FFF_FFFF, 32'h8000_0000, 1'b1, 32'h0000_0000},  // R4
    {32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 32'h0000_0000},  // R5
    {32'h1234_5678, 32'h7FFF_FFE0, 1'b0, 32'h1234_5678}   // R6
  };

  initial begin
    #(20ns * 200000);
    if (!done) begin
      nFail++; nRun++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // R8: output is zero during reset
    dataIn = 32'hDEAD_BEEF; countIn = 32'h0000_0003;
    repeat (3) @(negedge clk);
    check("R8 in reset", dataOut, 32'h0);
    rstN = 1'b1;

    foreach (VEC[i]) begin
      apply(VEC[i][96:65], VEC[i][64:33], VEC[i][32]);
      check($sformatf("R1-R6 vector %0d", i), dataOut, VEC[i][31:0]);
    end

    // Sweep: sign x low field x mode over random data (R1 R2 R3 R4 R5)
    for (int s = 0; s < 2; s++)
      for (int low = 0; low < 32; low++)
        for (int m = 0; m < 2; m++)
          for (int r = 0; r < 3; r++) begin
            logic [31:0] d, c;
            d = (r == 0) ? 32'h8000_0001 : $urandom;
            c = {s[0], 26'h0, low[4:0]};
            apply(d, c, m[0]);
            check(s ? "R2/R3 sweep" : "R1 sweep", dataOut, refShift(d, c, m[0]));
          end

    // R6: junk in bits 30..5 must not change the result
    for (int j = 0; j < 40; j++) begin
      logic [31:0] d, c, junk;
      d = $urandom; c = $urandom; junk = $urandom & 32'h7FFF_FFE0;
      apply(d, c | junk, j[0]);
      check("R6 ignored bits", dataOut, refShift(d, c & 32'h8000_001F, j[0]));
    end

    // R7: result tracks operands captured at the previous edge only
    @(negedge clk);
    dataIn = 32'h0000_0003; countIn = 32'h0000_0002; arithMode = 1'b0;
    @(posedge clk); #1;
    dataIn = 32'hFFFF_0000;  // changes after capture
    @(negedge clk);
    check("R7 latency", dataOut, 32'h0000_000C);
    @(negedge clk);
    check("R7 next op", dataOut, 32'hFFFC_0000);

    // R8: reset mid-run clears the result
    apply(32'hABCD_1234, 32'h0, 1'b1);
    check("R8 before reset", dataOut, 32'hABCD_1234);
    rstN = 1'b0;
    #3;
    check("R8 async reset", dataOut, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    check("R8 after reset", dataOut, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule